// File: doc/BRIEF.md
# Floating-Point Register Block Transfer Sequencer

This block turns one floating-point load or store instruction that moves one to four registers into a stream of micro-ops, one per cycle. Every register becomes a group of three micro-ops (sub-steps 0, 1 and 2). When the instruction asks for the base register to be updated, one more micro-op follows the last group and carries a ready-made base-update instruction word.

A one-bit mode input picks between two variants. The single variant always moves exactly one register. The multi variant reads a two-bit register count that is spread over two instruction bits. The instruction is captured through a valid/ready handshake, but only while the sequencer is idle. Micro-ops leave through a second valid/ready handshake. Each micro-op carries its group index, its sub-step, the transfer direction, the up bit, the start offset and a last flag.

Top module: `fpx_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `uop_valid` is 0.
- R2: An instruction is taken only on a cycle where `in_valid` and `in_ready` are both 1, and `in_ready` is 1 exactly when no micro-op is pending. The cycle after the last micro-op is accepted, `in_ready` is 1 again.
- R3: In multi mode (`in_multi`=1) the register count has instruction bit 22 as its high bit and bit 15 as its low bit, and the value 00 means four registers. In single mode the count is 1 whatever those bits hold. The number of micro-ops is 3 times the count, plus 1 when the writeback bit (bit 21) is set.
- R4: The micro-ops come out in order: group 0 with sub-steps 0,1,2, then group 1, and so on up to group count-1. `uop_group` and `uop_step` give the group index and the sub-step.
- R5: Every micro-op of an instruction carries its load bit (bit 20; 1 = load) on `uop_load` and its up bit (bit 23) on `uop_up`.
- R6: The displacement is instruction bits 7:0 shifted left by 2. Every micro-op carries a start offset equal to the displacement when the pre-index bit (bit 24) is 1, and 0 when it is 0.
- R7: When bit 21 is set, the final micro-op has `uop_is_wb`=1. Its `uop_wb_word` is built as follows: bits 31:28 are the instruction's bits 31:28, 0x02400000 is ORed in, the base register (instruction bits 19:16) is placed in both 19:16 and 15:12, and the displacement is ORed in. `uop_up` tells whether it adds (1) or subtracts (0). All other micro-ops have `uop_is_wb`=0.
- R8: `uop_last` is 1 on the final micro-op of the instruction and on no other micro-op.
- R9: While `uop_valid` is 1 and `uop_ready` is 0, every micro-op output holds its value.
- R10: Changes on `in_instr` and `in_multi` while a sequence is running have no effect on its micro-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Sequencer idle and able to take an instruction |
| in_instr | input | 32 | Instruction word |
| in_multi | input | 1 | 1 = multi-register variant, 0 = single-register variant |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_group | output | 2 | Register group index |
| uop_step | output | 2 | Sub-step inside the group, 0 to 2 |
| uop_load | output | 1 | 1 = load, 0 = store |
| uop_up | output | 1 | Up bit: offsets add when 1 |
| uop_offset | output | 10 | Start offset in bytes |
| uop_is_wb | output | 1 | This micro-op is the base update |
| uop_wb_word | output | 32 | Base-update instruction word |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The checker watches several properties on every cycle. It checks that stalled micro-ops hold still and that `in_ready` never overlaps `uop_valid`. It checks that sub-steps advance by one and stay below three, and that a base-update micro-op is always the last one. It also checks that the start offset stays fixed within an instruction and that the block is idle right after the last acceptance. Some behaviours only the bench's scenarios can show against its queue-based model. These are the exact count decoding from the scattered bits, including 00 meaning four and single mode ignoring those bits. The others are the offset value chosen by the pre-index bit, the layout of the base-update word, and the block's immunity to instruction changes in mid-sequence.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int INSTR_W  = 32;
    localparam int MAX_REGS = 4;
    localparam int STEPS    = 3;
    localparam int GRP_W    = $clog2(MAX_REGS);
    localparam int STEP_W   = $clog2(STEPS + 1);
    localparam int IMM_W    = 8;
    localparam int DISP_W   = IMM_W + 2;
    localparam int REG_W    = 4;

    // instruction bit positions the sequencer decodes
    localparam int B_PRE    = 24;
    localparam int B_UP     = 23;
    localparam int B_CNTHI  = 22;
    localparam int B_WB     = 21;
    localparam int B_LOAD   = 20;
    localparam int B_BASE   = 16;
    localparam int B_CNTLO  = 15;

    typedef struct packed {
        logic              busy;
        logic              wb_phase;
        logic [GRP_W-1:0]  group;
        logic [STEP_W-1:0] step;
        logic [GRP_W-1:0]  last_group;
        logic              do_wb;
        logic              load;
        logic              up;
        logic [DISP_W-1:0] offset;
        logic [INSTR_W-1:0] wb_word;
    } seq_state_t;
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
    import fpx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               multi,
    output logic [GRP_W-1:0]   last_group,
    output logic               pre,
    output logic               up,
    output logic               load,
    output logic               wb,
    output logic [DISP_W-1:0]  disp,
    output logic [REG_W-1:0]   base
);
    logic [GRP_W-1:0] raw_cnt;

    always_comb begin
        raw_cnt = GRP_W'({instr[B_CNTHI], instr[B_CNTLO]});
        // count-1 wraps: a raw value of zero gives MAX_REGS registers
        if (multi) begin
            last_group = raw_cnt - GRP_W'(1);
        end else begin
            last_group = '0;
        end
        pre  = instr[B_PRE];
        up   = instr[B_UP];
        load = instr[B_LOAD];
        wb   = instr[B_WB];
        disp = {instr[IMM_W-1:0], 2'b00};
        base = instr[B_BASE +: REG_W];
    end
endmodule

// File: rtl/fpx_wbword.sv
module fpx_wbword
    import fpx_pkg::*;
#(
    parameter logic [INSTR_W-1:0] OPC_BITS = 32'h0240_0000
) (
    input  logic [3:0]          cond,
    input  logic [REG_W-1:0]    base,
    input  logic [DISP_W-1:0]   disp,
    output logic [INSTR_W-1:0]  word
);
    always_comb begin
        word        = OPC_BITS;
        word[31:28] = cond;
        word[19:16] = base;
        word[15:12] = base;
        word        = word | INSTR_W'(disp);
    end
endmodule

// File: rtl/fpx_seq.sv
module fpx_seq
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_instr,
    input  logic               in_multi,
    output logic               uop_valid,
    input  logic               uop_ready,
    output logic [1:0]         uop_group,
    output logic [1:0]         uop_step,
    output logic               uop_load,
    output logic               uop_up,
    output logic [9:0]         uop_offset,
    output logic               uop_is_wb,
    output logic [31:0]        uop_wb_word,
    output logic               uop_last
);
    localparam logic [STEP_W-1:0] STEP_END = STEP_W'(STEPS - 1);

    seq_state_t s_d, s_q;

    logic [GRP_W-1:0]   dec_last;
    logic               dec_pre, dec_up, dec_load, dec_wb;
    logic [DISP_W-1:0]  dec_disp;
    logic [REG_W-1:0]   dec_base;
    logic [INSTR_W-1:0] dec_word;

    fpx_decode u_decode (
        .instr      (in_instr),
        .multi      (in_multi),
        .last_group (dec_last),
        .pre        (dec_pre),
        .up         (dec_up),
        .load       (dec_load),
        .wb         (dec_wb),
        .disp       (dec_disp),
        .base       (dec_base)
    );

    fpx_wbword u_wbword (
        .cond (in_instr[31:28]),
        .base (dec_base),
        .disp (dec_disp),
        .word (dec_word)
    );

    logic group_end, seq_end;

    always_comb begin
        group_end = (s_q.step == STEP_END);
        seq_end   = s_q.wb_phase ||
                    (!s_q.do_wb && group_end && (s_q.group == s_q.last_group));
        s_d = s_q;
        if (!s_q.busy) begin
            if (in_valid) begin
                s_d.busy       = 1'b1;
                s_d.wb_phase   = 1'b0;
                s_d.group      = '0;
                s_d.step       = '0;
                s_d.last_group = dec_last;
                s_d.do_wb      = dec_wb;
                s_d.load       = dec_load;
                s_d.up         = dec_up;
                s_d.offset     = dec_pre ? dec_disp : '0;
                s_d.wb_word    = dec_word;
            end
        end else if (uop_ready) begin
            if (seq_end) begin
                s_d.busy     = 1'b0;
                s_d.wb_phase = 1'b0;
            end else if (group_end) begin
                if (s_q.group == s_q.last_group) begin
                    s_d.wb_phase = 1'b1;
                end else begin
                    s_d.group = s_q.group + GRP_W'(1);
                    s_d.step  = '0;
                end
            end else begin
                s_d.step = s_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready    = !s_q.busy;
    assign uop_valid   = s_q.busy;
    assign uop_group   = s_q.group;
    assign uop_step    = s_q.step;
    assign uop_load    = s_q.load;
    assign uop_up      = s_q.up;
    assign uop_offset  = s_q.offset;
    assign uop_is_wb   = s_q.wb_phase;
    assign uop_wb_word = s_q.wb_word;
    assign uop_last    = s_q.busy && seq_end;
endmodule

// File: rtl/fpx_seq_chk.sv
module fpx_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        uop_valid,
    input logic        uop_ready,
    input logic [1:0]  uop_group,
    input logic [1:0]  uop_step,
    input logic        uop_load,
    input logic        uop_up,
    input logic [9:0]  uop_offset,
    input logic        uop_is_wb,
    input logic [31:0] uop_wb_word,
    input logic        uop_last
);
    assert_ready_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !uop_valid);

    assert_idle_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_last) |=> in_ready);

    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> (uop_step < 2'd3));

    assert_step_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && !uop_last && !uop_is_wb && uop_step != 2'd2)
        |=> (uop_valid && uop_step == $past(uop_step) + 2'd1 && $stable(uop_group)));

    assert_offset_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && !uop_last) |=> ($stable(uop_offset) && $stable(uop_up)
        && $stable(uop_load)));

    assert_wb_is_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_is_wb) |-> uop_last);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_group) && $stable(uop_step)
        && $stable(uop_is_wb) && $stable(uop_last) && $stable(uop_offset)
        && $stable(uop_wb_word)));
endmodule

bind fpx_seq fpx_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .uop_valid   (uop_valid),
    .uop_ready   (uop_ready),
    .uop_group   (uop_group),
    .uop_step    (uop_step),
    .uop_load    (uop_load),
    .uop_up      (uop_up),
    .uop_offset  (uop_offset),
    .uop_is_wb   (uop_is_wb),
    .uop_wb_word (uop_wb_word),
    .uop_last    (uop_last)
);

// File: tb/fpx_seq_bench.sv
module fpx_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        in_multi = 1'b0;
    logic        uop_valid;
    logic        uop_ready = 1'b1;
    logic [1:0]  uop_group;
    logic [1:0]  uop_step;
    logic        uop_load;
    logic        uop_up;
    logic [9:0]  uop_offset;
    logic        uop_is_wb;
    logic [31:0] uop_wb_word;
    logic        uop_last;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit stall_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int grp;
        int stp;
        bit load;
        bit up;
        int offset;
        bit is_wb;
        logic [31:0] word;
        bit last;
    } exp_t;

    exp_t expq[$];

    always #4 clk = ~clk;

    fpx_seq u_fpx_seq (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference: expand an accepted instruction into its expected micro-ops
    task automatic expand(input logic [31:0] ins, input bit multi);
        int n;
        int disp;
        int start;
        bit wb;
        logic [31:0] w;
        n = multi ? int'({ins[22], ins[15]}) : 1;
        if (n == 0) n = 4;
        disp  = int'(ins[7:0]) * 4;
        start = ins[24] ? disp : 0;
        wb    = ins[21];
        w = (ins & 32'hF000_0000) | 32'h0240_0000 | (32'(ins[19:16]) << 16)
            | (32'(ins[19:16]) << 12) | 32'(disp);
        for (int g = 0; g < n; g++) begin
            for (int s = 0; s < 3; s++) begin
                exp_t e;
                e.grp = g; e.stp = s; e.load = ins[20]; e.up = ins[23];
                e.offset = start; e.is_wb = 1'b0; e.word = w;
                e.last = !wb && (g == n - 1) && (s == 2);
                expq.push_back(e);
            end
        end
        if (wb) begin
            exp_t e;
            e.grp = 0; e.stp = 0; e.load = ins[20]; e.up = ins[23];
            e.offset = start; e.is_wb = 1'b1; e.word = w; e.last = 1'b1;
            expq.push_back(e);
        end
    endtask

    // monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
            chk(uop_valid == 1'b0, "R1 uop_valid in reset", uop_valid, 0);
        end else if (!done) begin
            chk(in_ready == (expq.size() == 0), "R2/R3 in_ready vs pending count",
                in_ready, expq.size() == 0);
            chk(uop_valid == (expq.size() != 0), "R3 uop_valid vs pending count",
                uop_valid, expq.size() != 0);
            if (uop_valid && uop_ready && expq.size() != 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(uop_is_wb == e.is_wb, "R7 is_wb", uop_is_wb, e.is_wb);
                if (!e.is_wb) begin
                    chk(uop_group == e.grp, "R4 group", uop_group, e.grp);
                    chk(uop_step == e.stp, "R4 step", uop_step, e.stp);
                end else begin
                    chk(uop_wb_word == e.word, "R7 wb word", uop_wb_word, e.word);
                end
                chk(uop_load == e.load, "R5 load", uop_load, e.load);
                chk(uop_up == e.up, "R5/R7 up", uop_up, e.up);
                chk(uop_offset == e.offset, "R6 offset", uop_offset, e.offset);
                chk(uop_last == e.last, "R8 last", uop_last, e.last);
            end
            if (in_valid && in_ready) expand(in_instr, in_multi);
        end
    end

    // consumer stalls and scrambling of the idle instruction bus (R9, R10)
    always @(posedge clk) begin
        #2;
        uop_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
        if (!in_valid) begin
            in_instr = $urandom;
            in_multi = $urandom_range(0, 1);
        end
    end

    task automatic issue(input logic [31:0] ins, input bit multi);
        @(posedge clk); #1;
        in_valid = 1'b1; in_instr = ins; in_multi = multi;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        do @(negedge clk); while (!in_ready);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R3: count 00 -> four registers, wb, pre-index, up, load
        issue(32'hE1B0_0012 & ~32'h0040_8000, 1'b1);
        // R3: count 01, no wb, post-index
        issue(32'h0080_80FF & ~32'h0060_0000, 1'b1);
        // R3: count 10, store, down, wb (R7 subtract)
        issue(32'h5161_7003 & ~32'h0080_8000, 1'b1);
        // R3: count 11, pre-index
        issue(32'h01D0_8044, 1'b1);
        // R3: single mode ignores count bits
        issue(32'hA1E3_8021, 1'b0);
        issue(32'h0000_0000, 1'b0);
        // R9 / R10: random stalls and scrambled bus during sequences
        stall_en = 1'b1;
        for (int k = 0; k < 40; k++) issue($urandom, $urandom_range(0, 1));
        stall_en = 1'b0;
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule